// File: doc/BRIEF.md
# Debounced Level Interrupt Controller

This block gathers sixteen asynchronous input lines and turns each into a level-sensitive interrupt source. Every line is brought into the clock domain by a two-stage synchroniser. Its synchronised level can be read back through a per-line read mask. Each line is compared against a programmable active level.

A per-line qualifier starts a debounce period when software writes its arm bit. The period is counted in pulses of a millisecond tick input. The qualifier latches a pending status bit once the line has held its active level for the programmed number of ticks. Pending bits are gated by per-line enables and then ORed into one interrupt output.

Software can get edge behaviour by flipping a line's active level after each service and re-arming it. The block only ever qualifies levels.

Each line's qualifier is a two-state machine:
- `CH_IDLE`: the line is disarmed and cannot set status. On an arm pulse it moves to `CH_QUAL` (transition *arm*).
- `CH_QUAL`: the line is counting ticks while its level matches.
  - On a mismatch the count restarts (transition *restart*, staying in `CH_QUAL`).
  - A new arm pulse also restarts the count (transition *rearm*).
  - When the count reaches the programmed value while the level matches, the machine sets the status bit and returns to `CH_IDLE` (transition *fire*).

Top module: `ext_irq_ctrl`

## Requirements
- R1: Reading offset 0x00 returns, in bits 15:0, the synchronised input levels ANDed with the read mask held at offset 0x04. The read mask is read back from 0x04. An input change is visible after at most three clocks.
- R2: Offset 0x14 holds the active level of each line: bit value 1 means a high level is active, and 0 means a low level is active.
- R3: Line n's debounce word is at offset 0x40 + 4·n. Only its low 12 bits are stored; the upper bits read as zero.
- R4: An armed line sets its status bit (offset 0x1C) only after its synchronised level has matched the active level through N tick pulses with no mismatch in between, N being its debounce word. A mismatch restarts the count. With N = 0 the bit sets on the first matching clock after arming.
- R5: Writing 1 to bit n at offset 0x28 arms line n. A line that is not armed never sets status. Each arming yields at most one status set. Offset 0x28 reads as zero.
- R6: Offset 0x18 holds the interrupt enables. Offset 0x20 reads the status ANDed with the enables. `irq_o` is high exactly when any bit of that result is set.
- R7: Writing 1 to bit n at offset 0x24 clears status bit n and leaves the other bits unchanged. If a set and a clear of the same bit fall in the same clock, the bit ends set.
- R8: After reset, every mask, active level, enable, status bit and debounce word is zero, and `irq_o` is low. Reads of unmapped or misaligned offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock pulse per millisecond, used as the debounce time base |
| pin_in | input | 16 | Asynchronous interrupt lines |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: sixteen lines, 12-bit debounce words and two synchroniser stages. It drives `ms_tick` itself, so a debounce of a few milliseconds shrinks to a few clocks. The exact tick on which a status bit sets, and the count restart after a glitch, can therefore be checked directly. Zero-length debounce on all sixteen lines lets random active levels, enables and inputs be checked in bulk. The same setting makes the same-clock set and clear collision reachable with two back-to-back writes.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    localparam int AW = 8;

    localparam logic [AW-1:0] OFS_LEVEL  = 8'h00;
    localparam logic [AW-1:0] OFS_RDMASK = 8'h04;
    localparam logic [AW-1:0] OFS_POL    = 8'h14;
    localparam logic [AW-1:0] OFS_ENA    = 8'h18;
    localparam logic [AW-1:0] OFS_RAW    = 8'h1C;
    localparam logic [AW-1:0] OFS_MASKED = 8'h20;
    localparam logic [AW-1:0] OFS_CLEAR  = 8'h24;
    localparam logic [AW-1:0] OFS_ARM    = 8'h28;
    localparam logic [AW-1:0] OFS_DBNC   = 8'h40;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_QUAL = 1'b1
    } chan_state_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/eirq_debounce.sv
module eirq_debounce
    import eirq_pkg::*;
#(
    parameter int DBW = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick_i,
    input  logic           lvl_i,
    input  logic           pol_i,
    input  logic           arm_i,
    input  logic [DBW-1:0] limit_i,
    output logic           fire_o,
    output logic           armed_o
);
    chan_state_e    state_q, state_d;
    logic [DBW-1:0] cnt_q;
    logic           match;

    assign match = (lvl_i == pol_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (arm_i) state_d = CH_QUAL;
            CH_QUAL: begin
                if (arm_i)       state_d = CH_QUAL;
                else if (fire_o) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        armed_o = (state_q == CH_QUAL);
        fire_o  = (state_q == CH_QUAL) && match && !arm_i && (cnt_q >= limit_i);
    end

    // tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (arm_i)              cnt_q <= '0;
        else if (state_q == CH_QUAL) begin
            if (!match)                        cnt_q <= '0;
            else if (tick_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
        end
    end

    p_fire_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (state_q == CH_IDLE));
    p_fire_on_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> (lvl_i == pol_i) && armed_o);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eirq_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int DBW    = 12,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_tick,
    input  logic [15:0]   pin_in,
    input  logic [7:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    input  logic          bus_we,
    output logic [31:0]   bus_rdata,
    output logic          irq_o
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0] lvl_sync;
    logic [NCH-1:0] rdmask_q, pol_q, ena_q, raw_q;
    logic [NCH-1:0] clr_vec, arm_vec, fire_vec, armed_vec, masked;
    logic [DBW-1:0] dbnc_q [NCH];
    logic [AW-1:0]  dofs;
    logic [CHW-1:0] didx;
    logic           dwin;

    eirq_sync #(.WIDTH(NCH), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_in[NCH-1:0]), .sync_o(lvl_sync)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            eirq_debounce #(.DBW(DBW)) u_dbnc (
                .clk(clk), .rst_n(rst_n), .tick_i(ms_tick),
                .lvl_i(lvl_sync[c]), .pol_i(pol_q[c]), .arm_i(arm_vec[c]),
                .limit_i(dbnc_q[c]), .fire_o(fire_vec[c]), .armed_o(armed_vec[c])
            );
        end
    endgenerate

    assign dofs    = bus_addr - OFS_DBNC;
    assign didx    = dofs[CHW+1:2];
    assign dwin    = (bus_addr >= OFS_DBNC) && (int'(dofs) < NCH * 4) && (dofs[1:0] == 2'b00);
    assign clr_vec = (bus_we && bus_addr == OFS_CLEAR) ? bus_wdata[NCH-1:0] : '0;
    assign arm_vec = (bus_we && bus_addr == OFS_ARM)   ? bus_wdata[NCH-1:0] : '0;
    assign masked  = raw_q & ena_q;
    assign irq_o   = |masked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdmask_q <= '0;
            pol_q    <= '0;
            ena_q    <= '0;
            raw_q    <= '0;
            for (int c = 0; c < NCH; c++) dbnc_q[c] <= '0;
        end else begin
            raw_q <= (raw_q & ~clr_vec) | fire_vec;
            if (bus_we) begin
                if (bus_addr == OFS_RDMASK) rdmask_q <= bus_wdata[NCH-1:0];
                if (bus_addr == OFS_POL)    pol_q    <= bus_wdata[NCH-1:0];
                if (bus_addr == OFS_ENA)    ena_q    <= bus_wdata[NCH-1:0];
                if (dwin)                   dbnc_q[didx] <= bus_wdata[DBW-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_LEVEL:  bus_rdata[NCH-1:0] = lvl_sync & rdmask_q;
            OFS_RDMASK: bus_rdata[NCH-1:0] = rdmask_q;
            OFS_POL:    bus_rdata[NCH-1:0] = pol_q;
            OFS_ENA:    bus_rdata[NCH-1:0] = ena_q;
            OFS_RAW:    bus_rdata[NCH-1:0] = raw_q;
            OFS_MASKED: bus_rdata[NCH-1:0] = masked;
            default:    if (dwin) bus_rdata[DBW-1:0] = dbnc_q[didx];
        endcase
    end

    p_status_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(raw_q) & ~$past(clr_vec) & ~raw_q) == '0));
    p_set_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(armed_vec)) == '0));
    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q == '0) |-> !irq_o);
endmodule

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic [15:0] pin_in = '0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    int checks = 0;
    int errors = 0;
    logic [31:0] v;

    ext_irq_ctrl i_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pin_in(pin_in),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] exp_raw(input logic [15:0] lv, input logic [15:0] pl);
        return ~(lv ^ pl);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] pins, pol, ena, clr, msk;
        void'($urandom(32'd1234));
        idle(3); rst_n = 1'b1; idle(2);
        // R8 reset state
        rd(8'h04, v); check("R8 rdmask", v, 0);
        rd(8'h14, v); check("R8 pol", v, 0);
        rd(8'h18, v); check("R8 ena", v, 0);
        rd(8'h1C, v); check("R8 raw", v, 0);
        rd(8'h40, v); check("R8 dbnc0", v, 0);
        check("R8 irq", irq_o, 0);

        // R1 random levels under random read mask
        for (int i = 0; i < 10; i++) begin
            pins = 16'($urandom); msk = 16'($urandom);
            pin_in = pins; wr(8'h04, {16'hFFFF, msk}); idle(3);
            rd(8'h00, v); check("R1 level", v, {16'h0, pins & msk});
            rd(8'h04, v); check("R1 mask", v, {16'h0, msk});
        end
        pin_in = '0;

        // R3 debounce word width
        wr(8'h54, 32'hFFFF_FABC);
        rd(8'h54, v); check("R3 dbnc5", v, 32'h0000_0ABC);

        // R4 tick count with a glitch restart on line 3
        wr(8'h14, 32'h0000_0008); wr(8'h18, 32'h0000_0088);
        wr(8'h4C, 32'd3); pin_in[3] = 1'b1; idle(4);
        wr(8'h28, 32'h0000_0008);
        ticks(2); idle(3);
        rd(8'h1C, v); check("R4 early", v, 0);
        pin_in[3] = 1'b0; idle(4); pin_in[3] = 1'b1; idle(4);
        ticks(2); idle(3);
        rd(8'h1C, v); check("R4 restart", v, 0);
        ticks(1); idle(2);
        rd(8'h1C, v); check("R4 set", v, 32'h8);
        rd(8'h20, v); check("R6 masked", v, 32'h8);
        check("R6 irq", irq_o, 1);

        // R7 clear, R5 one-shot while level still active
        wr(8'h24, 32'h0000_0008); idle(4);
        rd(8'h1C, v); check("R7/R5 cleared stays", v, 0);
        check("R6 irq low", irq_o, 0);
        rd(8'h28, v); check("R5 arm reads 0", v, 0);

        // R2 active-low on line 7, zero debounce
        pin_in[7] = 1'b0; idle(4);
        wr(8'h28, 32'h0000_0080); idle(2);
        rd(8'h1C, v); check("R2 active low", v, 32'h80);

        // R7 set wins over same-clock clear
        wr(8'h24, 32'h0000_0080);
        @(negedge clk); bus_addr = 8'h28; bus_wdata = 32'h80; bus_we = 1'b1;
        @(negedge clk); bus_addr = 8'h24; bus_wdata = 32'h80;
        @(negedge clk); bus_we = 1'b0; idle(1);
        rd(8'h1C, v); check("R7 set wins", v, 32'h80);

        // R2/R6/R7 random sweep with zero debounce
        wr(8'h4C, 0); wr(8'h54, 0);
        for (int i = 0; i < 8; i++) begin
            pins = 16'($urandom); pol = 16'($urandom);
            ena = 16'($urandom); clr = 16'($urandom);
            wr(8'h24, 32'hFFFF);
            pin_in = pins; wr(8'h14, {16'h0, pol}); wr(8'h18, {16'h0, ena}); idle(3);
            wr(8'h28, 32'hFFFF); idle(2);
            rd(8'h1C, v); check("R2 raw", v, {16'h0, exp_raw(pins, pol)});
            rd(8'h20, v); check("R6 masked", v, {16'h0, exp_raw(pins, pol) & ena});
            check("R6 irq", irq_o, |(exp_raw(pins, pol) & ena));
            wr(8'h24, {16'h0, clr}); idle(1);
            rd(8'h1C, v); check("R7 partial clear", v, {16'h0, exp_raw(pins, pol) & ~clr});
        end

        // R8 unmapped and misaligned offsets
        rd(8'h08, v); check("R8 unmapped 08", v, 0);
        rd(8'h3C, v); check("R8 unmapped 3C", v, 0);
        rd(8'h80, v); check("R8 unmapped 80", v, 0);
        rd(8'h42, v); check("R8 misaligned", v, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule